// File: doc/BRIEF.md
# Burst Read Output Sequencer

This block is the device-side output stage of a synchronous burst read path for a parallel memory with a 16-bit data bus. A burst-start strobe, sampled while chip enable is asserted, selects an access type. For synchronous reads, the block waits a programmable number of clocks. It then streams successive words from a word source onto the data bus. Each word occupies a data cycle of one or two clocks. A hold-setting bit chooses the length, and it defaults to two clocks.

The block also drives a WAIT status pin. For synchronous array reads, WAIT stays high while the initial latency runs. For other reads, it is driven low. For writes, it is floated. When either enable is deasserted, both the bus and WAIT are floated. One-clock hold suits a system only when the clock-to-output delay plus the host's setup time fits inside one clock period. For example, 20 ns plus 4 ns fits a 25 ns clock. Otherwise the two-clock setting must stay in force.

Top module: `burst_out_seq`

## Requirements
- R1: With the hold setting at two, each word stays on `dqOut` for exactly two clocks, and `wordReq` pulses once per data cycle, in the second clock of that cycle.
- R2: With the hold setting at one, `wordReq` is high in every streaming clock, and `dqOut` takes a new word at every clock edge.
- R3: After reset, the hold setting is two, `wordReq` is low, `wordIdx` is 0, the registered word is 0, and the remembered access type is asynchronous read.
- R4: A synchronous start sampled with latency L (L = 0 is treated as 1) puts the first word on `dqOut` L clocks after the sampling edge. The word is requested in the last latency clock.
- R5: When `ceN` is high, or `oeN` is high, both `dqOe` and `waitOe` are low.
- R6: For a synchronous array read (`accessKind` = 0), `waitOut` is high from the clock after the start edge until the first word is on the bus, and low while words stream.
- R7: For synchronous non-array reads (`accessKind` = 1) and asynchronous reads (`accessKind` = 2), `waitOut` is low and `waitOe` is high whenever both enables are low.
- R8: After a write start (`accessKind` = 3), `dqOe` and `waitOe` stay low even when both enables are low. An asynchronous or write start launches no burst.
- R9: `wordIdx` is cleared to 0 by every synchronous start and rises by one, wrapping, after each request. Raising `oeN` mid-burst neither pauses nor resets it.
- R10: A high `ceN` ends the burst. No request follows until a new start arrives, and a start sampled while `ceN` is high is ignored.
- R11: The hold setting is written with `cfgWe` and is captured at each synchronous start. A write made mid-burst changes only later bursts.
- R12: `dqOut` changes only at the clock edge that follows a `wordReq` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| startBurst | input | 1 | Access start strobe |
| accessKind | input | 2 | 0 sync array read, 1 sync non-array read, 2 async read, 3 write |
| latencyClks | input | LAT_W | Initial latency in clocks, sampled at start |
| cfgWe | input | 1 | Write strobe for the hold setting |
| cfgHoldTwo | input | 1 | New hold setting: 1 two clocks, 0 one clock |
| wordIn | input | DATA_W | Word returned by the source for `wordIdx`, same cycle |
| wordReq | output | 1 | Word fetch request; the word is captured at the next edge |
| wordIdx | output | IDX_W | Index of the word being requested |
| dqOut | output | DATA_W | Data bus value |
| dqOe | output | 1 | Data bus drive enable |
| waitOut | output | 1 | WAIT value, active high |
| waitOe | output | 1 | WAIT drive enable |

## Verification
The bench builds the block with a 4-bit word index. A single long one-clock-hold burst therefore carries `wordIdx` through its wrap back to 0. The default 16-bit data width and 4-bit latency field are kept, so latencies of 0, 1, 2 and 3 can be applied directly. These parameter values also let the bench reach a hold-setting write made mid-burst, an output-enable drop mid-burst, a restart during streaming, and a start that arrives while chip enable is high.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    KIND_SYNC_ARRAY = 2'd0,
    KIND_SYNC_OTHER = 2'd1,
    KIND_ASYNC_READ = 2'd2,
    KIND_WRITE      = 2'd3
  } access_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LATENCY = 2'd1,
    ST_STREAM  = 2'd2
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fetch;     // capture wordIn, advance index
    logic clearIdx;  // restart index at zero
  } dp_strobe_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             oeN,
  input  logic             startBurst,
  input  logic [1:0]       accessKind,
  input  logic [LAT_W-1:0] latencyClks,
  input  logic             cfgWe,
  input  logic             cfgHoldTwo,
  output dp_strobe_t       strobe,
  output logic             waitOut,
  output logic             waitOe,
  output logic             busOe
);

  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  seq_state_e       state;
  access_kind_e     kindQ;
  logic [LAT_W-1:0] latCnt;
  logic             phase;
  logic             holdQ;
  logic             holdCfg;

  access_kind_e     kindIn;
  logic             startOk;
  logic             isSync;
  logic             fetchCond;
  logic             fetch;
  logic [LAT_W-1:0] latLoad;

  assign kindIn  = access_kind_e'(accessKind);
  assign startOk = startBurst && !ceN;
  assign isSync  = (kindIn == KIND_SYNC_ARRAY) || (kindIn == KIND_SYNC_OTHER);
  assign latLoad = (latencyClks == '0) ? LAT_ONE : latencyClks;

  always_comb begin
    fetchCond = 1'b0;
    unique case (state)
      ST_LATENCY: fetchCond = (latCnt <= LAT_ONE);
      ST_STREAM:  fetchCond = !(holdQ && !phase);
      default:    fetchCond = 1'b0;
    endcase
  end

  assign fetch = !ceN && !startOk && fetchCond;

  always_comb begin
    strobe          = '0;
    strobe.fetch    = fetch;
    strobe.clearIdx = startOk && isSync;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindQ   <= KIND_ASYNC_READ;
      latCnt  <= '0;
      phase   <= 1'b0;
      holdQ   <= 1'b1;
      holdCfg <= 1'b1;
    end else begin
      if (cfgWe) holdCfg <= cfgHoldTwo;
      if (ceN) begin
        state <= ST_IDLE;
        phase <= 1'b0;
      end else if (startOk) begin
        kindQ  <= kindIn;
        phase  <= 1'b0;
        latCnt <= latLoad;
        holdQ  <= holdCfg;
        state  <= isSync ? ST_LATENCY : ST_IDLE;
      end else begin
        unique case (state)
          ST_LATENCY: begin
            if (fetch) begin
              state <= ST_STREAM;
              phase <= 1'b0;
            end else begin
              latCnt <= latCnt - LAT_ONE;
            end
          end
          ST_STREAM: phase <= fetch ? 1'b0 : 1'b1;
          default:   phase <= 1'b0;
        endcase
      end
    end
  end

  assign busOe   = !ceN && !oeN && (kindQ != KIND_WRITE);
  assign waitOe  = busOe;
  assign waitOut = (state == ST_LATENCY) && (kindQ == KIND_SYNC_ARRAY);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] wordIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [IDX_W-1:0]  wordIdx
);

  localparam logic [IDX_W-1:0] IDX_STEP = IDX_W'(1);

  logic [DATA_W-1:0] dataReg;
  logic [IDX_W-1:0]  idxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      idxReg  <= '0;
    end else if (strobe.clearIdx) begin
      idxReg  <= '0;
    end else if (strobe.fetch) begin
      dataReg <= wordIn;
      idxReg  <= idxReg + IDX_STEP;
    end
  end

  assign dqOut   = dataReg;
  assign wordIdx = idxReg;

endmodule

// File: rtl/burst_out_seq.sv
module burst_out_seq
  import burst_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAT_W  = 4,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              startBurst,
  input  logic [1:0]        accessKind,
  input  logic [LAT_W-1:0]  latencyClks,
  input  logic              cfgWe,
  input  logic              cfgHoldTwo,
  input  logic [DATA_W-1:0] wordIn,
  output logic              wordReq,
  output logic [IDX_W-1:0]  wordIdx,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              waitOut,
  output logic              waitOe
);

  dp_strobe_t strobe;

  burst_seq_ctrl #(.LAT_W(LAT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN),
    .startBurst(startBurst), .accessKind(accessKind),
    .latencyClks(latencyClks), .cfgWe(cfgWe), .cfgHoldTwo(cfgHoldTwo),
    .strobe(strobe), .waitOut(waitOut), .waitOe(waitOe), .busOe(dqOe)
  );

  burst_seq_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(wordIn),
    .dqOut(dqOut), .wordIdx(wordIdx)
  );

  assign wordReq = strobe.fetch;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              startBurst,
  input logic [1:0]        accessKind,
  input logic              wordReq,
  input logic [IDX_W-1:0]  wordIdx,
  input logic [DATA_W-1:0] dqOut,
  input logic              dqOe,
  input logic              waitOut,
  input logic              waitOe
);

  // R5
  float_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN) |-> (!dqOe && !waitOe));

  // R6
  wait_clears_on_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitOut && wordReq) |=> !waitOut);

  // R8
  write_floats_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startBurst && !ceN && accessKind == 2'd3) |=> (!dqOe && !waitOe));

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordReq |=> (wordIdx == IDX_W'($past(wordIdx) + 1'b1)));

  // R9
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startBurst && !ceN && !accessKind[1]) |=> (wordIdx == '0));

  // R10
  ce_stops_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !wordReq);

  // R12
  data_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordReq |=> $stable(dqOut));

endmodule

bind burst_out_seq burst_seq_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .startBurst(startBurst),
  .accessKind(accessKind), .wordReq(wordReq), .wordIdx(wordIdx),
  .dqOut(dqOut), .dqOe(dqOe), .waitOut(waitOut), .waitOe(waitOe)
);

// File: tb/test_burst_out_seq.sv
module test_burst_out_seq;

  localparam int DATA_W = 16;
  localparam int LAT_W  = 4;
  localparam int IDX_W  = 4;
  localparam int IDX_N  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1;
  logic              oeN = 1'b1;
  logic              startBurst = 1'b0;
  logic [1:0]        accessKind = 2'd0;
  logic [LAT_W-1:0]  latencyClks = '0;
  logic              cfgWe = 1'b0;
  logic              cfgHoldTwo = 1'b1;
  logic [DATA_W-1:0] wordIn;
  logic              wordReq;
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe, waitOut, waitOe;

  int    total = 0;
  int    bad = 0;
  string tag = "R3";

  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] wordOf(int idx);
    return DATA_W'(32'hC300 ^ (idx * 1031));
  endfunction

  assign wordIn = wordOf(int'(wordIdx));

  burst_out_seq #(.DATA_W(DATA_W), .LAT_W(LAT_W), .IDX_W(IDX_W)) i_burst_out_seq (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .startBurst(startBurst),
    .accessKind(accessKind), .latencyClks(latencyClks), .cfgWe(cfgWe),
    .cfgHoldTwo(cfgHoldTwo), .wordIn(wordIn), .wordReq(wordReq),
    .wordIdx(wordIdx), .dqOut(dqOut), .dqOe(dqOe), .waitOut(waitOut),
    .waitOe(waitOe)
  );

  // behavioural reference: mode 0 idle, 1 waiting out latency, 2 streaming
  int mMode = 0, mLeft = 0, mSecond = 0, mKind = 2, mHoldTwo = 1, mCfg = 1, mIdx = 0;
  logic [DATA_W-1:0] mWord = '0;

  function automatic bit expReq();
    bit want;
    if (ceN || startBurst) return 1'b0;
    want = (mMode == 1 && mLeft <= 1) || (mMode == 2 && !(mHoldTwo == 1 && mSecond == 0));
    return want;
  endfunction

  always @(posedge clk) begin
    bit f;
    if (!rstN) begin
      mMode = 0; mLeft = 0; mSecond = 0; mKind = 2; mHoldTwo = 1; mCfg = 1;
      mIdx = 0; mWord = '0;
    end else begin
      f = expReq();
      if (f) begin
        mWord = wordOf(mIdx);
        mIdx  = (mIdx + 1) % IDX_N;
      end
      if (ceN) begin
        mMode = 0; mSecond = 0;
      end else if (startBurst) begin
        mKind = int'(accessKind);
        mSecond = 0;
        mLeft = (latencyClks == 0) ? 1 : int'(latencyClks);
        mHoldTwo = mCfg;
        if (accessKind < 2) begin
          mMode = 1; mIdx = 0;
        end else begin
          mMode = 0;
        end
      end else if (mMode == 1) begin
        if (f) begin mMode = 2; mSecond = 0; end
        else mLeft = mLeft - 1;
      end else if (mMode == 2) begin
        mSecond = f ? 0 : 1;
      end
      if (cfgWe) mCfg = int'(cfgHoldTwo);
    end
  end

  task automatic check1(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit drive;
    drive = !ceN && !oeN && (mKind != 3);
    check1("wordReq", int'(wordReq), int'(expReq()));
    check1("wordIdx", int'(wordIdx), mIdx);
    check1("dqOut", int'(dqOut), int'(mWord));
    check1("dqOe", int'(dqOe), int'(drive));
    check1("waitOe", int'(waitOe), int'(drive));
    check1("waitOut", int'(waitOut), int'(mMode == 1 && mKind == 0));
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic startB(logic [1:0] kind, int lat);
    startBurst = 1'b1; accessKind = kind; latencyClks = LAT_W'(lat);
    tick();
    startBurst = 1'b0;
  endtask

  task automatic setHold(logic two);
    cfgWe = 1'b1; cfgHoldTwo = two;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired before the sequence ended");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    tag = "R3"; // reset state, floated bus
    run(2);
    rstN = 1'b1;
    run(2);
    ceN = 1'b0; oeN = 1'b0;
    run(2);

    tag = "R1"; // default two-clock hold, array read with latency 3 (R4, R6)
    startB(2'd0, 3);
    run(14);

    tag = "R2"; // one-clock hold written, then captured at next start (R11)
    setHold(1'b0);
    startB(2'd0, 2);
    run(6);
    tag = "R11";
    setHold(1'b1); // mid-burst write: current burst keeps one-clock hold
    run(6);
    startB(2'd0, 1);
    run(8);

    tag = "R7"; // non-array read; WAIT driven low
    startB(2'd1, 1);
    run(5);
    tag = "R5"; // output enable dropped mid-burst; index keeps running (R9)
    oeN = 1'b1;
    run(4);
    oeN = 1'b0;
    run(3);

    tag = "R7";
    startB(2'd2, 2);
    run(4);
    tag = "R8";
    startB(2'd3, 1);
    run(4);

    tag = "R10"; // chip enable high ends burst; start while disabled ignored
    startB(2'd0, 2);
    run(5);
    ceN = 1'b1;
    run(2);
    startB(2'd0, 1);
    run(2);
    ceN = 1'b0;
    run(4);

    tag = "R4"; // latency 0 treated as 1
    startB(2'd0, 0);
    run(6);

    tag = "R9"; // restart mid-stream, then wrap the index with one-clock hold
    startB(2'd1, 2);
    run(5);
    setHold(1'b0);
    startB(2'd0, 1);
    run(22);

    tag = "R12";
    setHold(1'b1);
    startB(2'd1, 3);
    run(10);

    finishRun();
  end

endmodule